// File: doc/BRIEF.md
# Infrared Pulse-Width Transmitter with Carrier Modulation

This block turns a queue of pulse-width words into an infrared drive waveform. Each word gives a 16-bit width and a level. The block holds its output at that level for a time set by the width and a shared clock divider. Words are written into a small FIFO and drained in order, with no gap between consecutive pulses. The block raises a service request when the FIFO needs refilling, and it shows busy while a pulse is on the pin.

When modulation is on, the block gates a carrier onto the burst periods. The carrier period is sixteen divided ticks, and a 4-bit code sets how many of those ticks are high. The carrier restarts its phase at the start of every pulse, so each burst begins on a high portion. Bursts normally go on marks. A polarity control moves them onto spaces, and a final inversion control flips the pin, including its idle level.

Top module: `ir_tx`

## Requirements
- R1: After synchronous reset (with `out_invert`=0), `ir_out`=0, `busy`=0, `fifo_full`=0 and `svc_req`=1, because the FIFO is empty.
- R2: The FIFO holds 8 words. `fifo_full` is 1 when it holds 8. A write while the FIFO is full and no word is taken is dropped.
- R3: A word of width w lasts exactly (4*w+3)*(car_divider+1) clock cycles. The next queued word starts in the following cycle, with no gap.
- R4: With `tx_enable`=1, the first clock edge that sees a non-empty FIFO while idle starts the oldest word. `busy` is 1 from that edge on.
- R5: With `mod_enable`=0, during a pulse the pin (before inversion) equals the word's level bit, where 1 is a mark.
- R6: With `mod_enable`=1, a divided tick lasts car_divider+1 cycles. Within a burst, tick t of the pulse (t counted from 0 at the pulse start) is high when (t mod 16) <= duty_code, and low otherwise. A period of 16 ticks therefore has duty (duty_code+1)/16.
- R7: With `burst_on_space`=0, bursts occur on words with level 1. With `burst_on_space`=1, bursts occur on words with level 0, and words with level 1 give a steady low.
- R8: `out_invert`=1 inverts the final pin in every state, idle included.
- R9: With `svc_on_empty`=0, `svc_req` is 1 when the FIFO holds 4 words or fewer. With `svc_on_empty`=1, it is 1 only when the FIFO is empty.
- R10: When the last pulse ends and the FIFO is empty, `busy` drops in the next cycle and the pin returns to the idle level (0 before inversion).
- R11: Lowering `tx_enable` ends the pulse in progress. `busy` is 0 and the pin is idle from the next edge, and the words still queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and reference for all timing |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write one word into the FIFO this cycle |
| wr_width | input | 16 | Width field of the written word |
| wr_level | input | 1 | Level of the written word, 1 for mark |
| tx_enable | input | 1 | Allow the FIFO to be drained onto the pin |
| mod_enable | input | 1 | Gate the carrier onto burst periods |
| car_divider | input | 16 | Tick length minus one, in clock cycles |
| duty_code | input | 4 | High ticks per 16-tick carrier period, minus one |
| burst_on_space | input | 1 | Put bursts on spaces instead of marks |
| out_invert | input | 1 | Invert the final pin level |
| svc_on_empty | input | 1 | Request service only when the FIFO is empty |
| ir_out | output | 1 | Infrared drive output |
| busy | output | 1 | A pulse is being sent |
| svc_req | output | 1 | FIFO refill request |
| fifo_full | output | 1 | FIFO holds the maximum number of words |

## Verification
The hardest case to reach from the ports is a chain of back-to-back pulses in which the carrier phase must restart exactly at each word boundary while the tick prescaler wraps in the same cycle. To reach it, the stimulus fills the FIFO while the transmitter is disabled and then enables it. All queued words then play without a break. Every cycle of the run is compared against a model built from the word list, the divider and the duty code. Random runs vary the divider, duty, polarity, inversion and the mix of widths down to zero, so boundaries fall at many different phases.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    // Width field of one queued word
    localparam int PW_BITS = 16;
    // Carrier period is 2**PH_BITS divided ticks
    localparam int PH_BITS = 4;
    // Pulse tick counter covers (width << 2) | 3
    localparam int TICK_BITS = PW_BITS + 2;

    typedef struct packed {
        logic               level;
        logic [PW_BITS-1:0] width;
    } tx_word_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_t;

    // Ticks remaining after the first one: ((w << 2) | 3) - 1
    function automatic logic [TICK_BITS-1:0] ticks_after_first(input logic [PW_BITS-1:0] w);
        return {w, 2'b10};
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  tx_word_t      din,
    input  logic          pop,
    output tx_word_t      dout,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);
    tx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic            do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/ir_tx_timebase.sv
module ir_tx_timebase
    import ir_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic [DIV_W-1:0]   divider,
    output logic               tick,
    output logic [PH_BITS-1:0] phase
);
    logic [DIV_W-1:0] pre;

    assign tick = run && (pre >= divider);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            phase <= '0;
        end else if (restart || !run) begin
            pre   <= '0;
            phase <= '0;
        end else if (tick) begin
            pre   <= '0;
            phase <= phase + 1'b1;
        end else begin
            pre   <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
    import ir_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     fifo_empty,
    input  tx_word_t head,
    input  logic     tick,
    output logic     load,
    output logic     active,
    output logic     level
);
    seq_state_t           state;
    logic [TICK_BITS-1:0] remain;
    logic                 last_tick;

    assign active    = (state == SEQ_SEND);
    assign last_tick = active && tick && (remain == '0);
    assign load      = enable && !fifo_empty && (!active || last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            remain <= '0;
            level  <= 1'b0;
        end else if (!enable) begin
            state  <= SEQ_IDLE;
        end else if (load) begin
            state  <= SEQ_SEND;
            level  <= head.level;
            remain <= ticks_after_first(head.width);
        end else if (last_tick) begin
            state  <= SEQ_IDLE;
        end else if (active && tick) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/ir_tx_shaper.sv
module ir_tx_shaper
    import ir_tx_pkg::*;
(
    input  logic               active,
    input  logic               level,
    input  logic [PH_BITS-1:0] phase,
    input  logic [PH_BITS-1:0] duty,
    input  logic               mod_en,
    input  logic               burst_on_space,
    input  logic               invert,
    output logic               pin
);
    logic envelope, burst, carrier_hi, raw;

    always_comb begin
        envelope   = active && level;
        burst      = active && (level ^ burst_on_space);
        carrier_hi = (phase <= duty);
        raw        = mod_en ? (burst && carrier_hi) : envelope;
        pin        = raw ^ invert;
    end

endmodule

// File: rtl/ir_tx.sv
module ir_tx
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [PW_BITS-1:0] wr_width,
    input  logic               wr_level,
    input  logic               tx_enable,
    input  logic               mod_enable,
    input  logic [DIV_W-1:0]   car_divider,
    input  logic [PH_BITS-1:0] duty_code,
    input  logic               burst_on_space,
    input  logic               out_invert,
    input  logic               svc_on_empty,
    output logic               ir_out,
    output logic               busy,
    output logic               svc_req,
    output logic               fifo_full
);
    tx_word_t           wr_word, head_word;
    logic [CW-1:0]      fifo_fill;
    logic               fifo_empty;
    logic               seq_load, seq_level, div_tick;
    logic [PH_BITS-1:0] car_phase;

    assign wr_word = '{level: wr_level, width: wr_width};
    assign svc_req = svc_on_empty ? fifo_empty : (fifo_fill <= CW'(HALF));

    ir_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_valid),
        .din   (wr_word),
        .pop   (seq_load),
        .dout  (head_word),
        .fill  (fifo_fill),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    ir_tx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (tx_enable),
        .fifo_empty (fifo_empty),
        .head       (head_word),
        .tick       (div_tick),
        .load       (seq_load),
        .active     (busy),
        .level      (seq_level)
    );

    ir_tx_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (seq_load),
        .divider (car_divider),
        .tick    (div_tick),
        .phase   (car_phase)
    );

    ir_tx_shaper u_shape (
        .active         (busy),
        .level          (seq_level),
        .phase          (car_phase),
        .duty           (duty_code),
        .mod_en         (mod_enable),
        .burst_on_space (burst_on_space),
        .invert         (out_invert),
        .pin            (ir_out)
    );

endmodule

// File: rtl/ir_tx_chk.sv
module ir_tx_chk
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_enable,
    input logic               busy,
    input logic               ir_out,
    input logic               out_invert,
    input logic               mod_enable,
    input logic [PH_BITS-1:0] duty_code,
    input logic [PH_BITS-1:0] car_phase,
    input logic [CW-1:0]      fifo_fill,
    input logic               fifo_empty
);
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_fill <= CW'(DEPTH));

    assert_start_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!fifo_empty));

    assert_carrier_low_part_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && mod_enable && (car_phase > duty_code)) |-> (ir_out == out_invert));

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ir_out == out_invert));

    assert_disable_stops_R11: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !busy);

endmodule

bind ir_tx ir_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_enable  (tx_enable),
    .busy       (busy),
    .ir_out     (ir_out),
    .out_invert (out_invert),
    .mod_enable (mod_enable),
    .duty_code  (duty_code),
    .car_phase  (car_phase),
    .fifo_fill  (fifo_fill),
    .fifo_empty (fifo_empty)
);

// File: tb/tb_ir_tx.sv
`timescale 1ns/1ps
module tb_ir_tx;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid, wr_level, tx_enable, mod_enable;
    logic [15:0] wr_width, car_divider;
    logic [3:0]  duty_code;
    logic        burst_on_space, out_invert, svc_on_empty;
    logic        ir_out, busy, svc_req, fifo_full;

    always #2 clk = ~clk;

    ir_tx dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_width(wr_width),
        .wr_level(wr_level), .tx_enable(tx_enable), .mod_enable(mod_enable),
        .car_divider(car_divider), .duty_code(duty_code),
        .burst_on_space(burst_on_space), .out_invert(out_invert),
        .svc_on_empty(svc_on_empty), .ir_out(ir_out), .busy(busy),
        .svc_req(svc_req), .fifo_full(fifo_full)
    );

    int checks = 0;
    int errors = 0;
    int qw [8];
    bit ql [8];
    int qn = 0;
    int cdiv, cduty;
    bit cmod, cpol, cinv;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int d, input int n, input bit m, input bit p, input bit v);
        cdiv = d; cduty = n; cmod = m; cpol = p; cinv = v;
        car_divider = 16'(d); duty_code = 4'(n); mod_enable = m;
        burst_on_space = p; out_invert = v;
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic push(input int w, input bit l);
        wr_valid = 1'b1; wr_width = 16'(w); wr_level = l;
        @(negedge clk);
        wr_valid = 1'b0;
        if (qn < 8) begin
            qw[qn] = w; ql[qn] = l; qn++;
        end
    endtask

    function automatic int pulse_len(input int i);
        return (4 * qw[i] + 3) * (cdiv + 1);
    endfunction

    function automatic bit exp_pin(input int k);
        int start = 0;
        for (int i = 0; i < qn; i++) begin
            if (k < start + pulse_len(i)) begin
                int off = k - start;
                int ph  = (off / (cdiv + 1)) % 16;
                bit env = cmod ? ((ql[i] ^ cpol) && (ph <= cduty)) : ql[i];
                return env ^ cinv;
            end
            start += pulse_len(i);
        end
        return cinv;
    endfunction

    // Words queued while disabled; enable and compare every cycle.
    task automatic run_queue();
        int total = 0;
        int bad_pin = -1, bad_busy = -1;
        bit act_pin = 0;
        string tag;
        for (int i = 0; i < qn; i++) total += pulse_len(i);
        tag = cmod ? (cpol ? "R7" : "R6") : "R5";
        if (cinv) tag = {tag, " R8"};
        tx_enable = 1'b1;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            if (k == 0) chk(busy == 1'b1, "R4 start latency", int'(busy), 1);
            if (busy !== 1'b1 && bad_busy < 0) bad_busy = k;
            if (ir_out !== exp_pin(k) && bad_pin < 0) begin
                bad_pin = k; act_pin = ir_out;
            end
        end
        chk(bad_busy < 0, "R3 pulse timing (first bad cycle)", bad_busy, -1);
        chk(bad_pin < 0, {tag, " waveform"}, int'(act_pin), int'(exp_pin(bad_pin)));
        @(negedge clk);
        chk(busy == 1'b0 && ir_out == cinv, "R10 drain to idle",
            int'({busy, ir_out}), int'({1'b0, cinv}));
        tx_enable = 1'b0;
        qn = 0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst = 1'b1; wr_valid = 1'b0; wr_width = '0; wr_level = 1'b0;
        tx_enable = 1'b0; svc_on_empty = 1'b0;
        set_cfg(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ir_out == 0 && busy == 0 && fifo_full == 0 && svc_req == 1, "R1 reset outputs",
            int'({ir_out, busy, fifo_full, svc_req}), 1);

        // R9 half-empty threshold, R2 fill and drop
        set_cfg(1, 5, 1, 0, 0);
        for (int i = 1; i <= 8; i++) begin
            push(i % 3, i % 2);
            chk(svc_req == (i <= 4), "R9 half-empty request", int'(svc_req), int'(i <= 4));
        end
        chk(fifo_full == 1'b1, "R2 full flag", int'(fifo_full), 1);
        push(9, 1);   // dropped; model keeps 8 words
        run_queue();
        chk(fifo_full == 1'b0, "R2 full clears after drain", int'(fifo_full), 0);

        // R9 empty-only mode
        svc_on_empty = 1'b1;
        @(negedge clk);
        chk(svc_req == 1'b1, "R9 empty request", int'(svc_req), 1);
        set_cfg(0, 15, 1, 1, 1);
        for (int i = 0; i < 3; i++) begin
            push(0, i % 2);
            chk(svc_req == 1'b0, "R9 no request when not empty", int'(svc_req), 0);
        end
        run_queue();
        svc_on_empty = 1'b0;

        // R8 inversion while idle
        @(negedge clk);
        chk(ir_out == 1'b1, "R8 idle inverted", int'(ir_out), 1);
        set_cfg(0, 0, 0, 0, 0);
        @(negedge clk);

        // Directed corners: duty 0, unmodulated, space bursts
        set_cfg(2, 0, 1, 0, 0);
        push(2, 1); push(0, 0); push(1, 1);
        run_queue();
        set_cfg(0, 7, 0, 1, 0);
        push(3, 1); push(3, 1); push(1, 0);
        run_queue();
        set_cfg(1, 3, 1, 1, 0);
        push(4, 0); push(2, 1); push(0, 0);
        run_queue();

        // R11 abort mid-pulse
        set_cfg(1, 7, 1, 0, 0);
        push(6, 1); push(2, 0);
        tx_enable = 1'b1;
        repeat (6) @(negedge clk);
        tx_enable = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && ir_out == 1'b0, "R11 abort to idle", int'({busy, ir_out}), 0);
        tx_enable = 1'b1;
        for (int g = 0; g < 400 && (busy || g < 2); g++) @(negedge clk);
        tx_enable = 1'b0;
        qn = 0;
        @(negedge clk);

        // Random runs
        for (int r = 0; r < 30; r++) begin
            int nw = 1 + int'($urandom_range(7));
            set_cfg(int'($urandom_range(3)), int'($urandom_range(15)),
                    1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
            @(negedge clk);
            for (int i = 0; i < nw; i++)
                push(int'($urandom_range(5)), 1'($urandom_range(1)));
            run_queue();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule